// File: doc/BRIEF.md
# Memory Extension Field Controller

This block holds the small field registers that widen a word address into a physical address. A data field, an instruction field and an instruction-field buffer each hold `FIELD_W` bits. A user-mode buffer and a user-mode flag are one bit each. A save register holds a packed copy of the user buffer, the instruction buffer and the data field, so that these can be restored later. An extension register selects one of the three fields for use by external memory logic.

Each register has its own operation-select input, and all of them update on the same rising clock edge. A register loads from fixed bit slices of the accumulator, the instruction word or the switch word, or from one of its neighbours. Within each word, bit 0 in the numbering below is the most significant bit.

Alongside the registers, the block forms a physical address with a combinational path. This address is the word address with a field placed on top of it, and the kind of memory cycle chooses that field. Every pin is a plain control or data pin: there is no streaming handshake, and an operation code takes effect on every clock edge.

Top module: `mx_field_ctrl`

## Requirements
- R1: While `rst_n` is low, every register output is zero, whatever the clock is doing. This covers the data field, instruction field, instruction buffer, user buffer, user flag, save register and extension field.
- R2: The data field uses `data_op` codes 0 to 5. Code 0 holds, 1 clears, 2 loads accumulator bits 9–11, 3 loads instruction bits 6–8, 4 loads save-register bits 4–6 (`save_reg[2:0]`) and 5 loads switch bits 9–11.
- R3: The instruction buffer uses `ibuf_op` codes 0 to 4. Code 0 holds, 1 clears, 2 loads accumulator bits 6–8, 3 loads instruction bits 6–8 and 4 loads save-register bits 1–3 (`save_reg[5:3]`).
- R4: The instruction field uses `inst_op` codes 0 to 3. Code 0 holds, 1 clears, 2 copies the instruction buffer and 3 loads switch bits 6–8. A copy takes the buffer value from before the edge, even when the buffer itself loads on that same edge.
- R5: When `save_en` is 1, the save register loads the concatenation {user buffer, instruction buffer, data field}, using the values from before the edge. The user buffer goes in the MSB. When `save_en` is 0, the save register holds.
- R6: The user buffer uses `ubuf_op` codes 0 to 4. Code 0 holds, 1 clears, 2 sets, 3 loads accumulator bit 5 and 4 loads save-register bit 0 (`save_reg[6]`).
- R7: The user flag uses `uflag_op` codes 0 to 3. Code 0 holds, 1 clears, 2 sets and 3 copies the pre-edge user buffer.
- R8: The extension field uses `ext_op` codes 0 to 4. Code 0 holds, 1 clears, 2 takes the data field, 3 takes the instruction field and 4 takes the instruction buffer, each as it stood before the edge.
- R9: `phys_addr` is {field, `word_addr`} and is formed in the same cycle. The field is chosen by `cyc_kind`: 0 gives zero, 1 the instruction buffer, 2 the instruction field and 3 the data field.
- R10: The operation codes above the defined range hold their register. These are `data_op` 6–7, `ibuf_op` 5–7, `ubuf_op` 5–7 and `ext_op` 5–7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_in | input | WORD_W | Accumulator word |
| ir_in | input | WORD_W | Instruction word |
| sw_in | input | WORD_W | Switch word |
| word_addr | input | WORD_W | Word address for the current memory cycle |
| data_op | input | 3 | Data field operation |
| ibuf_op | input | 3 | Instruction buffer operation |
| inst_op | input | 2 | Instruction field operation |
| ubuf_op | input | 3 | User buffer operation |
| uflag_op | input | 2 | User flag operation |
| save_en | input | 1 | Pack the fields into the save register |
| ext_op | input | 3 | Extension field operation |
| cyc_kind | input | 2 | Memory cycle kind for address forming |
| data_fld | output | FIELD_W | Data field |
| inst_fld | output | FIELD_W | Instruction field |
| inst_buf | output | FIELD_W | Instruction buffer |
| user_buf | output | 1 | User buffer |
| user_flag | output | 1 | User flag |
| save_reg | output | 2*FIELD_W+1 | Save register |
| ext_fld | output | FIELD_W | Extension field |
| phys_addr | output | WORD_W+FIELD_W | Physical address |

## Verification
The bench builds the block with its default parameters, which give 3-bit fields over 12-bit words. At that size, a sweep that applies every code of every 3-bit selector, each with all eight field values in the source slices, covers the whole operation space. This includes the reserved codes. A long run of mixed random operations then covers combinations across registers, such as a save and a restore on the same edge or a buffer load next to a field copy. It also checks the physical address for every cycle kind.

// File: rtl/mx_pkg.sv
package mx_pkg;
  typedef enum logic [2:0] {
    DOP_HOLD = 3'd0, DOP_CLR = 3'd1, DOP_ACC = 3'd2,
    DOP_IR = 3'd3, DOP_SAVE = 3'd4, DOP_SW = 3'd5
  } data_op_e;

  typedef enum logic [2:0] {
    BOP_HOLD = 3'd0, BOP_CLR = 3'd1, BOP_ACC = 3'd2,
    BOP_IR = 3'd3, BOP_SAVE = 3'd4
  } ibuf_op_e;

  typedef enum logic [1:0] {
    IOP_HOLD = 2'd0, IOP_CLR = 2'd1, IOP_BUF = 2'd2, IOP_SW = 2'd3
  } inst_op_e;

  typedef enum logic [2:0] {
    UBOP_HOLD = 3'd0, UBOP_CLR = 3'd1, UBOP_SET = 3'd2,
    UBOP_ACC = 3'd3, UBOP_SAVE = 3'd4
  } ubuf_op_e;

  typedef enum logic [1:0] {
    UFOP_HOLD = 2'd0, UFOP_CLR = 2'd1, UFOP_SET = 2'd2, UFOP_BUF = 2'd3
  } uflag_op_e;

  typedef enum logic [2:0] {
    EOP_HOLD = 3'd0, EOP_CLR = 3'd1, EOP_DATA = 3'd2,
    EOP_INST = 3'd3, EOP_BUF = 3'd4
  } ext_op_e;

  typedef enum logic [1:0] {
    CYC_ZERO = 2'd0, CYC_BUF = 2'd1, CYC_INST = 2'd2, CYC_DATA = 2'd3
  } cyc_e;
endpackage

// File: rtl/mx_field_bank.sv
module mx_field_bank
  import mx_pkg::*;
#(
  parameter int FIELD_W = 3,
  localparam int SAVE_W = 2 * FIELD_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*FIELD_W-1:0] acc_lo,
  input  logic [FIELD_W-1:0]   ir_fld,
  input  logic [2*FIELD_W-1:0] sw_lo,
  input  logic                 user_buf,
  input  logic [2:0]           data_op,
  input  logic [2:0]           ibuf_op,
  input  logic [1:0]           inst_op,
  input  logic                 save_en,
  output logic [FIELD_W-1:0]   data_fld,
  output logic [FIELD_W-1:0]   inst_fld,
  output logic [FIELD_W-1:0]   inst_buf,
  output logic [SAVE_W-1:0]    save_reg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_fld <= '0;
      inst_fld <= '0;
      inst_buf <= '0;
      save_reg <= '0;
    end else begin
      case (data_op)
        DOP_CLR:  data_fld <= '0;
        DOP_ACC:  data_fld <= acc_lo[FIELD_W-1:0];
        DOP_IR:   data_fld <= ir_fld;
        DOP_SAVE: data_fld <= save_reg[FIELD_W-1:0];
        DOP_SW:   data_fld <= sw_lo[FIELD_W-1:0];
        default:  data_fld <= data_fld;
      endcase
      case (ibuf_op)
        BOP_CLR:  inst_buf <= '0;
        BOP_ACC:  inst_buf <= acc_lo[2*FIELD_W-1:FIELD_W];
        BOP_IR:   inst_buf <= ir_fld;
        BOP_SAVE: inst_buf <= save_reg[2*FIELD_W-1:FIELD_W];
        default:  inst_buf <= inst_buf;
      endcase
      case (inst_op)
        IOP_CLR: inst_fld <= '0;
        IOP_BUF: inst_fld <= inst_buf;
        IOP_SW:  inst_fld <= sw_lo[2*FIELD_W-1:FIELD_W];
        default: inst_fld <= inst_fld;
      endcase
      if (save_en) save_reg <= {user_buf, inst_buf, data_fld};
    end
  end

  p_field_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_op == IOP_BUF) |=> (inst_fld == $past(inst_buf)));

  p_save_pack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    save_en |=> (save_reg == $past({user_buf, inst_buf, data_fld})));

  p_save_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !save_en |=> $stable(save_reg));
endmodule

// File: rtl/mx_user_mode.sv
module mx_user_mode
  import mx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_bit,
  input  logic       save_msb,
  input  logic [2:0] ubuf_op,
  input  logic [1:0] uflag_op,
  output logic       user_buf,
  output logic       user_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_buf  <= 1'b0;
      user_flag <= 1'b0;
    end else begin
      case (ubuf_op)
        UBOP_CLR:  user_buf <= 1'b0;
        UBOP_SET:  user_buf <= 1'b1;
        UBOP_ACC:  user_buf <= acc_bit;
        UBOP_SAVE: user_buf <= save_msb;
        default:   user_buf <= user_buf;
      endcase
      case (uflag_op)
        UFOP_CLR: user_flag <= 1'b0;
        UFOP_SET: user_flag <= 1'b1;
        UFOP_BUF: user_flag <= user_buf;
        default:  user_flag <= user_flag;
      endcase
    end
  end

  p_ubuf_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ubuf_op == UBOP_SAVE) |=> (user_buf == $past(save_msb)));

  p_uflag_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uflag_op == UFOP_BUF) |=> (user_flag == $past(user_buf)));
endmodule

// File: rtl/mx_addr_sel.sv
module mx_addr_sel
  import mx_pkg::*;
#(
  parameter int FIELD_W = 3,
  parameter int WORD_W  = 12,
  localparam int PHYS_W = WORD_W + FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         ext_op,
  input  logic [1:0]         cyc_kind,
  input  logic [FIELD_W-1:0] data_fld,
  input  logic [FIELD_W-1:0] inst_fld,
  input  logic [FIELD_W-1:0] inst_buf,
  input  logic [WORD_W-1:0]  word_addr,
  output logic [FIELD_W-1:0] ext_fld,
  output logic [PHYS_W-1:0]  phys_addr
);
  logic [FIELD_W-1:0] cyc_fld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_fld <= '0;
    end else begin
      case (ext_op)
        EOP_CLR:  ext_fld <= '0;
        EOP_DATA: ext_fld <= data_fld;
        EOP_INST: ext_fld <= inst_fld;
        EOP_BUF:  ext_fld <= inst_buf;
        default:  ext_fld <= ext_fld;
      endcase
    end
  end

  always_comb begin
    case (cyc_kind)
      CYC_BUF:  cyc_fld = inst_buf;
      CYC_INST: cyc_fld = inst_fld;
      CYC_DATA: cyc_fld = data_fld;
      default:  cyc_fld = '0;
    endcase
  end

  assign phys_addr = {cyc_fld, word_addr};

  p_ext_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_op == EOP_DATA) |=> (ext_fld == $past(data_fld)));

  p_ext_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_op == EOP_BUF) |=> (ext_fld == $past(inst_buf)));

  p_data_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == CYC_DATA) |-> (phys_addr[PHYS_W-1:WORD_W] == data_fld));
endmodule

// File: rtl/mx_field_ctrl.sv
module mx_field_ctrl #(
  parameter int FIELD_W = 3,
  parameter int WORD_W  = 12,
  localparam int SAVE_W = 2 * FIELD_W + 1,
  localparam int PHYS_W = WORD_W + FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  acc_in,
  input  logic [WORD_W-1:0]  ir_in,
  input  logic [WORD_W-1:0]  sw_in,
  input  logic [WORD_W-1:0]  word_addr,
  input  logic [2:0]         data_op,
  input  logic [2:0]         ibuf_op,
  input  logic [1:0]         inst_op,
  input  logic [2:0]         ubuf_op,
  input  logic [1:0]         uflag_op,
  input  logic               save_en,
  input  logic [2:0]         ext_op,
  input  logic [1:0]         cyc_kind,
  output logic [FIELD_W-1:0] data_fld,
  output logic [FIELD_W-1:0] inst_fld,
  output logic [FIELD_W-1:0] inst_buf,
  output logic               user_buf,
  output logic               user_flag,
  output logic [SAVE_W-1:0]  save_reg,
  output logic [FIELD_W-1:0] ext_fld,
  output logic [PHYS_W-1:0]  phys_addr
);
  localparam int UB_BIT = 2 * FIELD_W;

  logic unused_bits;
  assign unused_bits = ^{acc_in[WORD_W-1:UB_BIT+1], ir_in[WORD_W-1:UB_BIT],
                         ir_in[FIELD_W-1:0], sw_in[WORD_W-1:UB_BIT]};

  mx_field_bank #(.FIELD_W(FIELD_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_lo   (acc_in[UB_BIT-1:0]),
    .ir_fld   (ir_in[UB_BIT-1:FIELD_W]),
    .sw_lo    (sw_in[UB_BIT-1:0]),
    .user_buf (user_buf),
    .data_op  (data_op),
    .ibuf_op  (ibuf_op),
    .inst_op  (inst_op),
    .save_en  (save_en),
    .data_fld (data_fld),
    .inst_fld (inst_fld),
    .inst_buf (inst_buf),
    .save_reg (save_reg)
  );

  mx_user_mode u_user (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_bit   (acc_in[UB_BIT]),
    .save_msb  (save_reg[SAVE_W-1]),
    .ubuf_op   (ubuf_op),
    .uflag_op  (uflag_op),
    .user_buf  (user_buf),
    .user_flag (user_flag)
  );

  mx_addr_sel #(.FIELD_W(FIELD_W), .WORD_W(WORD_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_op    (ext_op),
    .cyc_kind  (cyc_kind),
    .data_fld  (data_fld),
    .inst_fld  (inst_fld),
    .inst_buf  (inst_buf),
    .word_addr (word_addr),
    .ext_fld   (ext_fld),
    .phys_addr (phys_addr)
  );
endmodule

// File: tb/tb_mx_field_ctrl.sv
`timescale 1ns/1ps
module tb_mx_field_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] acc_in = '0, ir_in = '0, sw_in = '0, word_addr = '0;
  logic [2:0]  data_op = '0, ibuf_op = '0, ubuf_op = '0, ext_op = '0;
  logic [1:0]  inst_op = '0, uflag_op = '0, cyc_kind = '0;
  logic        save_en = 1'b0;
  logic [2:0]  data_fld, inst_fld, inst_buf, ext_fld;
  logic        user_buf, user_flag;
  logic [6:0]  save_reg;
  logic [14:0] phys_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [2:0] m_df, m_if, m_ib, m_ext;
  logic       m_ub, m_uf;
  logic [6:0] m_sf;

  always #2.5 clk = ~clk;

  mx_field_ctrl dut (
    .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .ir_in(ir_in), .sw_in(sw_in),
    .word_addr(word_addr), .data_op(data_op), .ibuf_op(ibuf_op),
    .inst_op(inst_op), .ubuf_op(ubuf_op), .uflag_op(uflag_op),
    .save_en(save_en), .ext_op(ext_op), .cyc_kind(cyc_kind),
    .data_fld(data_fld), .inst_fld(inst_fld), .inst_buf(inst_buf),
    .user_buf(user_buf), .user_flag(user_flag), .save_reg(save_reg),
    .ext_fld(ext_fld), .phys_addr(phys_addr)
  );

  task automatic chk(input string tag, input logic [14:0] act, input logic [14:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIL%s %s: actual %0h expected %0h", "", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] exp_phys();
    logic [2:0] f;
    case (cyc_kind)
      2'd1: f = m_ib;
      2'd2: f = m_if;
      2'd3: f = m_df;
      default: f = 3'd0;
    endcase
    return {f, word_addr};
  endfunction

  task automatic check_all();
    chk("R2 data field", {12'd0, data_fld}, {12'd0, m_df});
    chk("R3 instruction buffer", {12'd0, inst_buf}, {12'd0, m_ib});
    chk("R4 instruction field", {12'd0, inst_fld}, {12'd0, m_if});
    chk("R5 save register", {8'd0, save_reg}, {8'd0, m_sf});
    chk("R6 user buffer", {14'd0, user_buf}, {14'd0, m_ub});
    chk("R7 user flag", {14'd0, user_flag}, {14'd0, m_uf});
    chk("R8 extension field", {12'd0, ext_fld}, {12'd0, m_ext});
    chk("R9 physical address", phys_addr, exp_phys());
  endtask

  task automatic model_clear();
    m_df = '0; m_if = '0; m_ib = '0; m_ext = '0; m_ub = 1'b0; m_uf = 1'b0; m_sf = '0;
  endtask

  task automatic tick();
    logic [2:0] n_df, n_if, n_ib, n_ext;
    logic       n_ub, n_uf;
    logic [6:0] n_sf;
    n_df = m_df; n_if = m_if; n_ib = m_ib; n_ext = m_ext;
    n_ub = m_ub; n_uf = m_uf; n_sf = m_sf;
    case (data_op)
      3'd1: n_df = 3'd0;
      3'd2: n_df = acc_in[2:0];
      3'd3: n_df = ir_in[5:3];
      3'd4: n_df = m_sf[2:0];
      3'd5: n_df = sw_in[2:0];
      default: ;
    endcase
    case (ibuf_op)
      3'd1: n_ib = 3'd0;
      3'd2: n_ib = acc_in[5:3];
      3'd3: n_ib = ir_in[5:3];
      3'd4: n_ib = m_sf[5:3];
      default: ;
    endcase
    case (inst_op)
      2'd1: n_if = 3'd0;
      2'd2: n_if = m_ib;
      2'd3: n_if = sw_in[5:3];
      default: ;
    endcase
    case (ubuf_op)
      3'd1: n_ub = 1'b0;
      3'd2: n_ub = 1'b1;
      3'd3: n_ub = acc_in[6];
      3'd4: n_ub = m_sf[6];
      default: ;
    endcase
    case (uflag_op)
      2'd1: n_uf = 1'b0;
      2'd2: n_uf = 1'b1;
      2'd3: n_uf = m_ub;
      default: ;
    endcase
    if (save_en) n_sf = {m_ub, m_ib, m_df};
    case (ext_op)
      3'd1: n_ext = 3'd0;
      3'd2: n_ext = m_df;
      3'd3: n_ext = m_if;
      3'd4: n_ext = m_ib;
      default: ;
    endcase
    @(posedge clk);
    #1;
    m_df = n_df; m_if = n_if; m_ib = n_ib; m_ext = n_ext;
    m_ub = n_ub; m_uf = n_uf; m_sf = n_sf;
    check_all();
    @(negedge clk);
  endtask

  task automatic all_hold();
    data_op = 3'd0; ibuf_op = 3'd0; inst_op = 2'd0; ubuf_op = 3'd0;
    uflag_op = 2'd0; save_en = 1'b0; ext_op = 3'd0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs zero while reset is held
    chk("R1 data field", {12'd0, data_fld}, 15'd0);
    chk("R1 instruction field", {12'd0, inst_fld}, 15'd0);
    chk("R1 instruction buffer", {12'd0, inst_buf}, 15'd0);
    chk("R1 user bits", {13'd0, user_buf, user_flag}, 15'd0);
    chk("R1 save register", {8'd0, save_reg}, 15'd0);
    chk("R1 extension field", {12'd0, ext_fld}, 15'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Exhaustive code sweep: every selector code with every field value
    for (int code = 0; code < 8; code++) begin
      for (int v = 0; v < 8; v++) begin
        acc_in = {4{v[2:0]}};
        ir_in = {4{3'(7 - v)}};
        sw_in = {4{3'(v ^ 5)}};
        word_addr = 12'(v * 515 + code);
        data_op = 3'(code); ibuf_op = 3'(code); ubuf_op = 3'(code);
        ext_op = 3'(code); inst_op = 2'(code); uflag_op = 2'(code);
        save_en = v[0];
        cyc_kind = 2'(v + code);
        tick();
      end
    end

    // R4: copy into instruction field takes buffer value before the edge
    all_hold();
    acc_in = 12'o0030; ibuf_op = 3'd2; tick();
    acc_in = 12'o0050; ibuf_op = 3'd2; inst_op = 2'd2; tick();
    chk("R4 same-edge copy", {12'd0, inst_fld}, 15'd3);
    chk("R4 buffer loaded", {12'd0, inst_buf}, 15'd5);

    // R10: reserved codes hold every register
    all_hold();
    acc_in = 12'o7777; ir_in = 12'o7777; sw_in = 12'o7777;
    data_op = 3'd1; ibuf_op = 3'd1; ubuf_op = 3'd1; ext_op = 3'd1; tick();
    data_op = 3'd2; ibuf_op = 3'd2; ubuf_op = 3'd3; tick();
    ext_op = 3'd2; all_hold(); ext_op = 3'd2; tick();
    for (int code = 5; code < 8; code++) begin
      all_hold();
      acc_in = '0; ir_in = '0; sw_in = '0;
      data_op = (code == 5) ? 3'd6 : 3'(code);
      ibuf_op = 3'(code); ubuf_op = 3'(code); ext_op = 3'(code);
      tick();
      chk("R10 data field held", {12'd0, data_fld}, 15'd7);
      chk("R10 buffer held", {12'd0, inst_buf}, 15'd7);
      chk("R10 user buffer held", {14'd0, user_buf}, 15'd1);
      chk("R10 extension held", {12'd0, ext_fld}, 15'd7);
    end

    // Mixed random operations
    for (int i = 0; i < 3000; i++) begin
      acc_in = 12'($urandom); ir_in = 12'($urandom); sw_in = 12'($urandom);
      word_addr = 12'($urandom);
      data_op = 3'($urandom); ibuf_op = 3'($urandom); inst_op = 2'($urandom);
      ubuf_op = 3'($urandom); uflag_op = 2'($urandom); ext_op = 3'($urandom);
      save_en = 1'($urandom); cyc_kind = 2'($urandom);
      tick();
    end

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    model_clear();
    chk("R1 async data field", {12'd0, data_fld}, 15'd0);
    chk("R1 async save register", {8'd0, save_reg}, 15'd0);
    chk("R1 async extension", {12'd0, ext_fld}, 15'd0);
    chk("R1 async user bits", {13'd0, user_buf, user_flag}, 15'd0);
    @(negedge clk);
    rst_n = 1'b1;
    all_hold();
    tick();
    finish_run();
  end
endmodule